// File: doc/BRIEF.md
# Vertical Sync Detector with Timeout

This block watches a sliced, already digitized composite sync stream that is sampled on the system clock. The stream is active low: a low level is the sync tip and a high level is blanking. The block measures how many clocks each low interval lasts. Short lows are horizontal or equalizing pulses. Lows that last more than half of a half-line are the broad serration intervals of the vertical interval. On the first rising edge that ends such a broad low, the block drives an active-low vertical sync pulse of fixed, programmable width. The falling edge of that pulse marks the start of the vertical period.

Some non-standard sources give no serrations and instead hold sync low for a long time. For these, a timeout forces the vertical pulse once the low time reaches a programmable delay. After each pulse the detector ignores broad lows until it has counted a set number of normal-length sync pulses, so each field gives at most one pulse. A separate monitor declares loss of signal when no falling sync edge arrives within a programmable window. While the signal is lost, the vertical output is held low. Every time constant is a parameter in clock cycles.

The controller has four states:
- `ST_LOST`: no signal; the vertical output is low.
- `ST_REARM`: counting normal pulses.
- `ST_ARMED`: waiting for a serration or a timeout.
- `ST_PULSE`: driving the vertical pulse.

Transitions:
- Any state goes to LOST when presence drops.
- LOST goes to REARM when presence returns.
- REARM goes to ARMED on the last required normal pulse.
- ARMED goes to PULSE on a serration edge or a timeout.
- PULSE goes to REARM when the width count expires.

Top module: `vsync_detect`

## Requirements
- R1: After reset, `vsync_n` is 0 (signal treated as lost) and `sig_ok` is 0.
- R2: In ARMED, a rising edge of `sync_n` (0 = sync tip) that ends a low interval of more than HALF_LINE_CYC/2 clocks drives `vsync_n` low from the clock edge that first samples the high level. A low of exactly HALF_LINE_CYC/2 clocks is a normal pulse and does not fire.
- R3: Each vertical pulse keeps `vsync_n` low for exactly VS_WIDTH_CYC clocks.
- R4: In ARMED, if `sync_n` is sampled low on DEFAULT_DLY_CYC consecutive clocks, `vsync_n` goes low from that clock edge, without waiting for a rising edge.
- R5: While a pulse is in progress, and after it ends, further serration edges and timeouts produce no pulse until the detector is re-armed.
- R6: Re-arming needs REARM_PULSES rising edges that end normal-length lows (at most HALF_LINE_CYC/2 clocks). Broad lows neither count toward this number nor reset the count.
- R7: `sig_ok` falls LOS_CYC clocks after the last sampled falling edge of `sync_n`. From the following clock, `vsync_n` is held low for as long as the signal stays lost.
- R8: `sig_ok` rises on the clock edge that samples a falling edge of `sync_n`. `vsync_n` returns high one clock later, and the detector must then re-arm before it can fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Sliced composite sync, low at sync tip, synchronous to clk |
| vsync_n | output | 1 | Vertical sync, active low |
| sig_ok | output | 1 | High while sync edges keep arriving |

## Verification
The bench drives whole fields of stimulus:
- Short horizontal lines and equalizing pulses, which must only re-arm the detector.
- A train of broad serrations, whose first edge alone must fire; the rest prove one pulse per field.
- A single long low, which separates the timeout path from the edge path.

Low intervals of exactly the threshold and one clock above it separate normal pulses from serrations. Three normal pulses followed by a serration, then a fourth pulse and another serration, pin the re-arm count. A long stretch with no edges, followed by recovery that starts with a serration, shows that lost signal holds the output low and that recovery still needs re-arming.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        ST_LOST  = 2'd0,
        ST_REARM = 2'd1,
        ST_ARMED = 2'd2,
        ST_PULSE = 2'd3
    } vsd_state_e;

endpackage

// File: rtl/vsd_low_timer.sv
module vsd_low_timer #(
    parameter int HALF_LINE_CYC   = 4000,
    parameter int DEFAULT_DLY_CYC = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic norm_rise,
    output logic serr_rise,
    output logic tmo_hit,
    output logic fall_seen
);

    localparam int SERR_THR = HALF_LINE_CYC / 2;
    localparam int CW       = $clog2(DEFAULT_DLY_CYC + 1);
    localparam logic [CW-1:0] THR_V  = CW'(SERR_THR);
    localparam logic [CW-1:0] DLY_M1 = CW'(DEFAULT_DLY_CYC - 1);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic          sync_d;
    logic [CW-1:0] low_cnt;
    logic          rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d  <= 1'b1;
            low_cnt <= '0;
        end else begin
            sync_d <= sync_n;
            if (sync_n) begin
                low_cnt <= '0;
            end else if (low_cnt != CNT_MAX) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign rise      = sync_n && !sync_d;
    assign fall_seen = !sync_n && sync_d;
    assign serr_rise = rise && (low_cnt > THR_V);
    assign norm_rise = rise && (low_cnt <= THR_V);
    assign tmo_hit   = !sync_n && (low_cnt == DLY_M1);

    AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> !tmo_hit); // R4

endmodule

// File: rtl/vsd_presence.sv
module vsd_presence #(
    parameter int LOS_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_seen,
    output logic present
);

    localparam int CW = $clog2(LOS_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LOS_CYC - 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            present  <= 1'b0;
        end else if (fall_seen) begin
            idle_cnt <= '0;
            present  <= 1'b1;
        end else if (idle_cnt == LAST) begin
            present  <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    AST_SIG_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |=> present); // R8

endmodule

// File: rtl/vsd_fsm.sv
module vsd_fsm
    import vsd_pkg::*;
#(
    parameter int VS_WIDTH_CYC = 28750,
    parameter int REARM_PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present,
    input  logic norm_rise,
    input  logic serr_rise,
    input  logic tmo_hit,
    output logic vsync_n
);

    localparam int WW = $clog2(VS_WIDTH_CYC + 1);
    localparam int HW = $clog2(REARM_PULSES + 1);
    localparam logic [WW-1:0] WC_LAST = WW'(VS_WIDTH_CYC - 1);
    localparam logic [HW-1:0] HC_LAST = HW'(REARM_PULSES - 1);

    vsd_state_e    state_q, state_d;
    logic [WW-1:0] wcnt;
    logic [HW-1:0] hcnt;

    always_comb begin
        state_d = state_q;
        if (!present) begin
            state_d = ST_LOST;
        end else begin
            unique case (state_q)
                ST_LOST:  state_d = ST_REARM;
                ST_REARM: if (norm_rise && hcnt == HC_LAST) state_d = ST_ARMED;
                ST_ARMED: if (serr_rise || tmo_hit) state_d = ST_PULSE;
                ST_PULSE: if (wcnt == WC_LAST) state_d = ST_REARM;
                default:  state_d = ST_LOST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOST;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            hcnt <= '0;
        end else begin
            if (state_q == ST_PULSE && state_d == ST_PULSE) begin
                wcnt <= wcnt + 1'b1;
            end else begin
                wcnt <= '0;
            end
            if (state_q == ST_REARM && state_d == ST_REARM) begin
                if (norm_rise) hcnt <= hcnt + 1'b1;
            end else begin
                hcnt <= '0;
            end
        end
    end

    always_comb begin
        vsync_n = !(state_q == ST_PULSE || state_q == ST_LOST);
    end

    AST_LOST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> !vsync_n); // R7

    AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) && $past(present)) |-> $past(serr_rise || tmo_hit)); // R2

    AST_ARM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REARM && !norm_rise) |=> (state_q != ST_ARMED)); // R6

endmodule

// File: rtl/vsync_detect.sv
module vsync_detect #(
    parameter int HALF_LINE_CYC   = 4000,
    parameter int DEFAULT_DLY_CYC = 7500,
    parameter int VS_WIDTH_CYC    = 28750,
    parameter int REARM_PULSES    = 8,
    parameter int LOS_CYC         = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic vsync_n,
    output logic sig_ok
);

    logic norm_rise;
    logic serr_rise;
    logic tmo_hit;
    logic fall_seen;

    vsd_low_timer #(
        .HALF_LINE_CYC  (HALF_LINE_CYC),
        .DEFAULT_DLY_CYC(DEFAULT_DLY_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .norm_rise(norm_rise),
        .serr_rise(serr_rise),
        .tmo_hit  (tmo_hit),
        .fall_seen(fall_seen)
    );

    vsd_presence #(
        .LOS_CYC(LOS_CYC)
    ) u_pres (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_seen(fall_seen),
        .present  (sig_ok)
    );

    vsd_fsm #(
        .VS_WIDTH_CYC(VS_WIDTH_CYC),
        .REARM_PULSES(REARM_PULSES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .present  (sig_ok),
        .norm_rise(norm_rise),
        .serr_rise(serr_rise),
        .tmo_hit  (tmo_hit),
        .vsync_n  (vsync_n)
    );

endmodule

// File: tb/sim_vsync_detect.sv
`timescale 1ns/1ps
module sim_vsync_detect;

    localparam int HL  = 40;
    localparam int DLY = 60;
    localparam int WID = 50;
    localparam int RA  = 4;
    localparam int LOS = 200;

    typedef struct {
        int    at;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1;
    logic vsync_n;
    logic sig_ok;

    int   cyc = 0;
    int   errors = 0;
    int   checks = 0;
    int   pulses_seen = 0;
    bit   finished = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    vsync_detect #(
        .HALF_LINE_CYC  (HL),
        .DEFAULT_DLY_CYC(DLY),
        .VS_WIDTH_CYC   (WID),
        .REARM_PULSES   (RA),
        .LOS_CYC        (LOS)
    ) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (sync_n),
        .vsync_n(vsync_n),
        .sig_ok (sig_ok)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input string tag);
        exp_t e;
        e.at  = at;
        e.tag = tag;
        expq.push_back(e);
    endtask

    // Scoreboard monitor: compares each vertical pulse against the queue.
    logic prev_vs = 1'b0;
    bit   in_pulse = 1'b0;
    int   wid_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_vs && !vsync_n && sig_ok) begin
                pulses_seen++;
                in_pulse = 1'b1;
                wid_cnt  = 1;
                if (expq.size() == 0) begin
                    chk(1'b0, "R5 unexpected pulse", cyc, -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(cyc == e.at, e.tag, cyc, e.at);
                end
            end else if (in_pulse && !vsync_n) begin
                wid_cnt++;
            end else if (in_pulse && vsync_n) begin
                in_pulse = 1'b0;
                chk(wid_cnt == WID, "R3 pulse width", wid_cnt, WID);
            end
            prev_vs <= vsync_n;
        end
    end

    task automatic hold(input logic v, input int n);
        sync_n = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic line_pulse();
        hold(1'b0, 8);
        hold(1'b1, 72);
    endtask

    task automatic eq_pulse();
        hold(1'b0, 4);
        hold(1'b1, 36);
    endtask

    task automatic serr(input bit expect_fire, input string tag);
        hold(1'b0, 34);
        if (expect_fire) push(cyc + 1, tag);
        hold(1'b1, 6);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", cyc, 0);
            summary();
        end
    end

    initial begin
        int base;
        int f;
        repeat (3) @(negedge clk);
        chk(vsync_n == 1'b0, "R1 vsync_n in reset", vsync_n, 0);
        chk(sig_ok == 1'b0, "R1 sig_ok in reset", sig_ok, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sig_ok == 1'b0, "R1 sig_ok idle", sig_ok, 0);

        // Field with serrations
        sync_n = 1'b0;
        @(negedge clk);
        chk(sig_ok == 1'b1, "R8 first edge", sig_ok, 1);
        repeat (7) @(negedge clk);
        hold(1'b1, 72);
        repeat (6) line_pulse();
        repeat (6) eq_pulse();
        serr(1'b1, "R2 serration fire");
        repeat (5) serr(1'b0, "");
        repeat (6) eq_pulse();
        repeat (4) line_pulse();
        chk(pulses_seen == 1, "R5 one pulse per field", pulses_seen, 1);

        // Timeout path
        repeat (2) line_pulse();
        push(cyc + DLY, "R4 timeout fire");
        hold(1'b0, 100);
        hold(1'b1, 60);
        chk(pulses_seen == 2, "R4 timeout count", pulses_seen, 2);

        // Re-arm boundary
        repeat (RA - 1) line_pulse();
        serr(1'b0, "");
        chk(pulses_seen == 2, "R6 not yet armed", pulses_seen, 2);
        line_pulse();
        serr(1'b1, "R6 armed after count");
        hold(1'b1, 60);
        repeat (RA) line_pulse();

        // Threshold boundary
        base = pulses_seen;
        hold(1'b0, HL / 2);
        hold(1'b1, 60);
        chk(pulses_seen == base, "R2 low at threshold", pulses_seen, base);
        hold(1'b0, HL / 2 + 1);
        push(cyc + 1, "R2 low above threshold");
        hold(1'b1, 79);
        repeat (RA) line_pulse();

        // Loss of signal
        f = cyc + 1;
        hold(1'b0, 8);
        sync_n = 1'b1;
        while (cyc < f + LOS - 1) @(negedge clk);
        chk(sig_ok == 1'b1, "R7 still present", sig_ok, 1);
        @(negedge clk);
        chk(sig_ok == 1'b0, "R7 loss declared", sig_ok, 0);
        @(negedge clk);
        chk(vsync_n == 1'b0, "R7 output held low", vsync_n, 0);
        repeat (40) @(negedge clk);
        chk(vsync_n == 1'b0, "R7 still held low", vsync_n, 0);

        // Recovery, starting with a serration
        base = pulses_seen;
        sync_n = 1'b0;
        @(negedge clk);
        chk(sig_ok == 1'b1, "R8 presence back", sig_ok, 1);
        @(negedge clk);
        chk(vsync_n == 1'b1, "R8 output released", vsync_n, 1);
        hold(1'b0, 32);
        hold(1'b1, 6);
        chk(pulses_seen == base, "R8 needs re-arm", pulses_seen, base);
        repeat (RA) line_pulse();
        serr(1'b1, "R8 fire after recovery");
        hold(1'b1, 80);

        chk(expq.size() == 0, "R3 all pulses seen", expq.size(), 0);
        chk(!in_pulse && vsync_n, "R3 pulse ended", vsync_n, 1);
        finished = 1'b1;
        summary();
    end

endmodule